// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the controlling state machine of a small 32-bit load/store processor together with the shared datapath it steers: program counter, instruction register, two operand latches, an ALU result latch, a memory data latch, a register file and one ALU. Every instruction starts with a fetch step and a decode step. After those it takes a path that depends on its class: an execute step, then possibly a memory step, then possibly a register write step. A branch or a jump finishes after three cycles. A register-register operation or a store takes four cycles. A load takes five.

All memory traffic goes through a single port, which carries both instruction fetches and data accesses. The port has an address, write data, a read strobe and a write strobe going out, and read data and a wait flag coming in. A memory that is not ready holds the wait flag high. While it does, the sequencer stays in its current step and keeps the address and strobe steady until the access completes.

Top module: `mcpu_core`

## Requirements
- R1: A synchronous reset puts the sequencer in the fetch step with PC = 0 and every register cleared. While reset is held, the port shows a read of address 0 and no write.
- R2: Each instruction begins with a fetch. The fetch reads memory at PC, loads the instruction register and sets PC to PC+4 in the cycle the access completes.
- R3: Decode latches operand A from register bits 25:21 and operand B from bits 20:16. It also computes a branch target equal to the incremented PC plus the sign-extended bits 15:0 shifted left by 2.
- R4: Opcode 0 is a register operation that writes its result to the register selected by bits 15:11. The function field (bits 5:0) selects the operation: 0x20 adds, 0x22 subtracts, 0x24 is bitwise AND, 0x25 is bitwise OR, and 0x00 shifts operand B left by the amount in bits 10:6. It takes 4 cycles.
- R5: Opcode 0x23 loads the word at A + sign-extended bits 15:0 into the register named by bits 20:16. It takes 5 cycles.
- R6: Opcode 0x2B writes operand B to A + sign-extended bits 15:0, with exactly one completed write. It takes 4 cycles.
- R7: Opcode 0x04 moves PC to the decode-time branch target when A equals B and leaves it at PC+4 otherwise. It takes 3 cycles either way.
- R8: Opcode 0x02 replaces PC bits 27:0 with bits 25:0 shifted left by 2 and keeps PC bits 31:28. It takes 3 cycles.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: While wait is high, the address, write data and strobe stay unchanged. Each wait cycle lengthens the instruction by exactly one cycle. Read and write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address of the current memory access |
| mem_wdata | output | 32 | Store data |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe (store) |
| mem_rdata | input | 32 | Read data from memory |
| mem_wait | input | 1 | Memory not ready; hold the current access |

## Verification
A memory stall can land on either of the two steps that drive a strobe: the fetch step, where the instruction register and PC updates are pending, or the memory step of a load or store, where the data latch or a write is pending. The bench runs one program several times and applies the same stall length to every access in each run, sweeping that length from zero to three cycles. In every stalled cycle it checks that the address and strobes have not moved. It also checks that each store completes exactly once with the right data, that the fetch address sequence is unchanged, and that the spacing between fetches equals the instruction's base cycle count plus the stall length times its number of memory accesses.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;
    localparam int OPC_W   = 6;
    localparam int IMM_W   = 16;
    localparam int JFLD_W  = 26;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_SHL = 6'h00;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [2:0] {
        STEP_FETCH, STEP_DECODE, STEP_EXEC, STEP_MEM, STEP_WB
    } step_t;

    typedef enum logic [2:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SHL
    } alu_op_t;

    typedef enum logic { SRC_A_PC, SRC_A_REG } src_a_t;

    typedef enum logic [1:0] {
        SRC_B_REG, SRC_B_IMM, SRC_B_IMM4, SRC_B_FOUR
    } src_b_t;

    typedef enum logic [1:0] { NPC_ALU, NPC_TARGET, NPC_JUMP } npc_t;

    typedef struct packed {
        logic    ir_en;
        logic    pc_en;
        npc_t    pc_src;
        logic    ab_en;
        logic    res_en;
        logic    mdr_en;
        src_a_t  src_a;
        src_b_t  src_b;
        alu_op_t alu_op;
        logic    rf_we;
        logic    rf_dst_rd;
        logic    rf_from_mdr;
        logic    addr_from_res;
        logic    rd_stb;
        logic    wr_stb;
    } ctl_t;

endpackage

// File: rtl/mcpu_regfile.sv
module mcpu_regfile #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [DATA_W-1:0] w_data
);
    localparam int NREG = 1 << IDX_W;

    logic [DATA_W-1:0] regs_q [NREG];
    logic [DATA_W-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
        if (we && (w_idx != '0)) regs_d[w_idx] = w_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

    // R9: index 0 never yields a nonzero value
    p_zero_read_r9: assert property (@(posedge clk) disable iff (rst)
        (ra_idx == '0) |-> (ra_data == '0));

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SH_W-1:0]   shamt,
    output logic [DATA_W-1:0] y,
    output logic              zero
);
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_SHL:  y = b << shamt;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcpu_seq.sv
module mcpu_seq
    import mcpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic [5:0]       funct,
    input  logic             alu_zero,
    input  logic             mem_wait,
    output ctl_t             ctl
);
    step_t step_d, step_q;
    alu_op_t fn_op;

    always_comb begin
        case (funct)
            FN_SUB:  fn_op = OP_SUB;
            FN_AND:  fn_op = OP_AND;
            FN_OR:   fn_op = OP_OR;
            FN_SHL:  fn_op = OP_SHL;
            default: fn_op = OP_ADD;
        endcase
    end

    always_comb begin
        ctl    = '0;
        step_d = step_q;
        case (step_q)
            STEP_FETCH: begin
                ctl.rd_stb = 1'b1;
                ctl.src_a  = SRC_A_PC;
                ctl.src_b  = SRC_B_FOUR;
                ctl.alu_op = OP_ADD;
                ctl.pc_src = NPC_ALU;
                if (!mem_wait) begin
                    ctl.ir_en = 1'b1;
                    ctl.pc_en = 1'b1;
                    step_d    = STEP_DECODE;
                end
            end
            STEP_DECODE: begin
                ctl.ab_en  = 1'b1;
                ctl.res_en = 1'b1;
                ctl.src_a  = SRC_A_PC;
                ctl.src_b  = SRC_B_IMM4;
                ctl.alu_op = OP_ADD;
                step_d     = STEP_EXEC;
            end
            STEP_EXEC: begin
                ctl.src_a = SRC_A_REG;
                case (opcode)
                    OPC_REG: begin
                        ctl.src_b  = SRC_B_REG;
                        ctl.alu_op = fn_op;
                        ctl.res_en = 1'b1;
                        step_d     = STEP_WB;
                    end
                    OPC_LOAD, OPC_STORE: begin
                        ctl.src_b  = SRC_B_IMM;
                        ctl.alu_op = OP_ADD;
                        ctl.res_en = 1'b1;
                        step_d     = STEP_MEM;
                    end
                    OPC_BEQ: begin
                        ctl.src_b  = SRC_B_REG;
                        ctl.alu_op = OP_SUB;
                        ctl.pc_src = NPC_TARGET;
                        ctl.pc_en  = alu_zero;
                        step_d     = STEP_FETCH;
                    end
                    OPC_JUMP: begin
                        ctl.pc_src = NPC_JUMP;
                        ctl.pc_en  = 1'b1;
                        step_d     = STEP_FETCH;
                    end
                    default: step_d = STEP_FETCH;
                endcase
            end
            STEP_MEM: begin
                ctl.addr_from_res = 1'b1;
                if (opcode == OPC_LOAD) ctl.rd_stb = 1'b1;
                else                    ctl.wr_stb = 1'b1;
                if (!mem_wait) begin
                    if (opcode == OPC_LOAD) begin
                        ctl.mdr_en = 1'b1;
                        step_d     = STEP_WB;
                    end else begin
                        step_d     = STEP_FETCH;
                    end
                end
            end
            STEP_WB: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_dst_rd   = (opcode == OPC_REG);
                ctl.rf_from_mdr = (opcode != OPC_REG);
                step_d          = STEP_FETCH;
            end
            default: step_d = STEP_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= STEP_FETCH;
        else     step_q <= step_d;
    end

    // R3: decode is always followed by execute
    p_decode_exec_r3: assert property (@(posedge clk) disable iff (rst)
        (step_q == STEP_DECODE) |=> (step_q == STEP_EXEC));

    // R10: a stalled access keeps its step
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ((ctl.rd_stb || ctl.wr_stb) && mem_wait) |=> $stable(step_q));

    // R10: read and write never together
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(ctl.rd_stb && ctl.wr_stb));

    // R1: register write only from the write step, never beside a strobe
    p_wb_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ctl.rf_we |-> !(ctl.rd_stb || ctl.wr_stb));

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_wait
);
    localparam int SH_W = RIDX_W;
    localparam int SX_W = XLEN - IMM_W;
    localparam int PCHI = XLEN - JFLD_W - 2;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] res;
        logic [XLEN-1:0] mdr;
    } dp_t;

    dp_t dp_d, dp_q;
    ctl_t ctl;

    logic [XLEN-1:0] ra_data, rb_data, alu_a, alu_b, alu_y, imm_sx, wb_data;
    logic [RIDX_W-1:0] wb_idx;
    logic alu_zero;

    assign imm_sx = {{SX_W{dp_q.ir[IMM_W-1]}}, dp_q.ir[IMM_W-1:0]};

    mcpu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .opcode   (dp_q.ir[XLEN-1 -: OPC_W]),
        .funct    (dp_q.ir[5:0]),
        .alu_zero (alu_zero),
        .mem_wait (mem_wait),
        .ctl      (ctl)
    );

    assign wb_idx  = ctl.rf_dst_rd ? dp_q.ir[15:11] : dp_q.ir[20:16];
    assign wb_data = ctl.rf_from_mdr ? dp_q.mdr : dp_q.res;

    mcpu_regfile #(.DATA_W(XLEN), .IDX_W(RIDX_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (dp_q.ir[25:21]),
        .rb_idx  (dp_q.ir[20:16]),
        .ra_data (ra_data),
        .rb_data (rb_data),
        .we      (ctl.rf_we),
        .w_idx   (wb_idx),
        .w_data  (wb_data)
    );

    always_comb begin
        alu_a = (ctl.src_a == SRC_A_PC) ? dp_q.pc : dp_q.opa;
        case (ctl.src_b)
            SRC_B_REG:  alu_b = dp_q.opb;
            SRC_B_IMM:  alu_b = imm_sx;
            SRC_B_IMM4: alu_b = imm_sx << 2;
            default:    alu_b = XLEN'(4);
        endcase
    end

    mcpu_alu #(.DATA_W(XLEN), .SH_W(SH_W)) u_alu (
        .op    (ctl.alu_op),
        .a     (alu_a),
        .b     (alu_b),
        .shamt (dp_q.ir[10:6]),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    always_comb begin
        dp_d = dp_q;
        if (ctl.ir_en)  dp_d.ir  = mem_rdata;
        if (ctl.ab_en) begin
            dp_d.opa = ra_data;
            dp_d.opb = rb_data;
        end
        if (ctl.res_en) dp_d.res = alu_y;
        if (ctl.mdr_en) dp_d.mdr = mem_rdata;
        if (ctl.pc_en) begin
            case (ctl.pc_src)
                NPC_TARGET: dp_d.pc = dp_q.res;
                NPC_JUMP:   dp_d.pc = {dp_q.pc[XLEN-1 -: PCHI], dp_q.ir[JFLD_W-1:0], 2'b00};
                default:    dp_d.pc = alu_y;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q    <= '0;
            dp_q.pc <= RESET_PC;
        end else begin
            dp_q    <= dp_d;
        end
    end

    assign mem_addr  = ctl.addr_from_res ? dp_q.res : dp_q.pc;
    assign mem_wdata = dp_q.opb;
    assign mem_rd    = ctl.rd_stb;
    assign mem_wr    = ctl.wr_stb;

    // R2: a completed fetch advances PC by four
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        ctl.ir_en |=> (dp_q.pc == $past(dp_q.pc) + XLEN'(4)));

    // R2: instruction register changes only on a completed fetch
    p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !ctl.ir_en |=> $stable(dp_q.ir));

    // R10: stalled access keeps address and data at the port
    p_port_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && mem_wait) |=>
            ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr)));

endmodule

// File: tb/mcpu_core_tb.sv
module mcpu_core_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic mem_rd, mem_wr;
    logic mem_wait = 1'b0;

    always #10 clk = ~clk;

    mcpu_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_rdata (mem_rdata),
        .mem_wait  (mem_wait)
    );

    logic [31:0] mem [256];
    assign mem_rdata = mem[mem_addr[9:2]];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int wlen = 0;
    int wcnt = 0;
    int n_st = 0;
    int n_f  = 0;
    logic [31:0] st_addr [16];
    logic [31:0] st_data [16];
    logic [31:0] f_addr  [32];
    int          f_cyc   [32];
    logic        was_wait = 1'b0;
    logic [31:0] p_addr;
    logic        p_rd, p_wr;

    localparam logic [31:0] VA = 32'h0000_000C;
    localparam logic [31:0] VB = 32'h8000_00F6;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic load_prog();
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[0]  = enc_i(6'h23, 0, 1, 16'h0100);
        mem[1]  = enc_i(6'h23, 0, 2, 16'h0104);
        mem[2]  = enc_r(1, 2, 3, 0, 6'h20);
        mem[3]  = enc_r(1, 2, 4, 0, 6'h22);
        mem[4]  = enc_r(1, 2, 5, 0, 6'h24);
        mem[5]  = enc_r(1, 2, 6, 0, 6'h25);
        mem[6]  = enc_r(0, 2, 7, 4, 6'h00);
        mem[7]  = enc_r(1, 2, 0, 0, 6'h20);
        mem[8]  = enc_i(6'h2B, 0, 3, 16'h0200);
        mem[9]  = enc_i(6'h2B, 0, 4, 16'h0204);
        mem[10] = enc_i(6'h2B, 0, 5, 16'h0208);
        mem[11] = enc_i(6'h2B, 0, 6, 16'h020C);
        mem[12] = enc_i(6'h2B, 0, 7, 16'h0210);
        mem[13] = enc_i(6'h2B, 0, 0, 16'h0214);
        mem[14] = enc_i(6'h04, 1, 2, 16'hFFFD);
        mem[15] = enc_i(6'h04, 1, 1, 16'h0001);
        mem[16] = enc_i(6'h2B, 0, 1, 16'h0218);
        mem[17] = enc_i(6'h23, 1, 8, 16'h00F8);
        mem[18] = enc_i(6'h2B, 0, 8, 16'h0218);
        mem[19] = {6'h02, 26'd21};
        mem[20] = enc_i(6'h2B, 0, 1, 16'h021C);
        mem[21] = enc_i(6'h2B, 0, 9, 16'h021C);
        mem[22] = {6'h02, 26'd22};
        mem[64] = VA;
        mem[65] = VB;
    endtask

    // memory model: stall each access wlen cycles, log completions
    always @(negedge clk) begin
        if (rst) begin
            mem_wait = 1'b0;
            wcnt     = 0;
            was_wait = 1'b0;
        end else begin
            if (was_wait) begin
                chk(mem_addr == p_addr, "R10 addr held", mem_addr, p_addr);
                chk(mem_rd == p_rd && mem_wr == p_wr, "R10 strobe held",
                    {30'b0, mem_rd, mem_wr}, {30'b0, p_rd, p_wr});
            end
            if (mem_rd && mem_wr) chk(1'b0, "R10 strobes exclusive", 32'h3, 32'h1);
            if (mem_rd || mem_wr) begin
                if (wcnt < wlen) begin
                    mem_wait = 1'b1;
                    wcnt++;
                end else begin
                    mem_wait = 1'b0;
                    wcnt     = 0;
                    if (mem_wr) begin
                        if (n_st < 16) begin
                            st_addr[n_st] = mem_addr;
                            st_data[n_st] = mem_wdata;
                        end
                        n_st++;
                        mem[mem_addr[9:2]] = mem_wdata;
                    end else if (mem_addr < 32'h100) begin
                        if (n_f < 32) begin
                            f_addr[n_f] = mem_addr;
                            f_cyc[n_f]  = cyc;
                        end
                        n_f++;
                    end
                end
            end else begin
                mem_wait = 1'b0;
            end
            was_wait = mem_wait;
            p_addr   = mem_addr;
            p_rd     = mem_rd;
            p_wr     = mem_wr;
        end
    end

    initial begin
        int exp_word [21];
        int base [21];
        int acc  [21];
        logic [31:0] exp_sa [8];
        logic [31:0] exp_sd [8];
        int k;
        k = 0;
        for (int w = 0; w <= 22; w++) begin
            if (w != 16 && w != 20) begin
                exp_word[k] = w;
                k++;
            end
        end
        exp_word[20] = 22;
        for (int i = 0; i < 21; i++) begin
            case (exp_word[i])
                0, 1, 17:                 begin base[i] = 5; acc[i] = 2; end
                2, 3, 4, 5, 6, 7:         begin base[i] = 4; acc[i] = 1; end
                8, 9, 10, 11, 12, 13, 18, 21: begin base[i] = 4; acc[i] = 2; end
                default:                  begin base[i] = 3; acc[i] = 1; end
            endcase
        end
        exp_sa[0] = 32'h200; exp_sd[0] = VA + VB;       // R4 add
        exp_sa[1] = 32'h204; exp_sd[1] = VA - VB;       // R4 sub
        exp_sa[2] = 32'h208; exp_sd[2] = VA & VB;       // R4 and
        exp_sa[3] = 32'h20C; exp_sd[3] = VA | VB;       // R4 or
        exp_sa[4] = 32'h210; exp_sd[4] = VB << 4;       // R4 shift
        exp_sa[5] = 32'h214; exp_sd[5] = 32'h0;         // R9 write to r0 ignored
        exp_sa[6] = 32'h218; exp_sd[6] = VB;            // R5 load via base+offset
        exp_sa[7] = 32'h21C; exp_sd[7] = 32'h0;         // R1 untouched register cleared

        for (int w = 0; w < 4; w++) begin
            int limit;
            wlen = w;
            load_prog();
            rst = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            // R1: reset state at the port
            chk(mem_rd && !mem_wr && mem_addr == 32'h0, "R1 reset state",
                {mem_addr[29:0], mem_rd, mem_wr}, 32'h2);
            n_st = 0;
            n_f  = 0;
            rst  = 1'b0;
            limit = 0;
            while (n_f < 21 && limit < 2000) begin
                @(posedge clk);
                limit++;
            end
            @(negedge clk);
            chk(n_f >= 21, "watchdog", 32'(n_f), 32'd21);
            if (n_f >= 21) begin
                // R7, R8: fetch order covers branch not taken, taken, and jump
                for (int i = 0; i < 21; i++)
                    chk(f_addr[i] == 32'(exp_word[i] * 4), "R7/R8 fetch order",
                        f_addr[i], 32'(exp_word[i] * 4));
                // R2, R4, R5, R6, R7, R8, R10: instruction length
                for (int i = 0; i < 20; i++)
                    chk(f_cyc[i+1] - f_cyc[i] == base[i] + w * acc[i], "R10 cycle count",
                        32'(f_cyc[i+1] - f_cyc[i]), 32'(base[i] + w * acc[i]));
                // R6: exactly the expected stores
                chk(n_st == 8, "R6 store count", 32'(n_st), 32'd8);
                for (int i = 0; i < 8; i++) begin
                    chk(st_addr[i] == exp_sa[i], "R6 store addr", st_addr[i], exp_sa[i]);
                    chk(st_data[i] == exp_sd[i], "R3 store data", st_data[i], exp_sd[i]);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule